// File: doc/BRIEF.md
# Latched Serial Control Register Port

This block receives configuration over a write-only three-wire serial link: a control clock, a data line and a latch strobe. Sixteen bits are shifted in, most significant first, on rising control-clock edges. A rising latch edge commits the word. The committed word is split into an input-format code, a soft power-down flag, a de-emphasis flag, a mute flag and a 10-bit attenuation value. A channel-select bit steers the attenuation value into either the left or the right volume register.

All three serial wires, the audio frame clock and the active-low power-down input are brought into the system clock domain through two-flop synchronisers. Edges are detected after synchronisation, so the system clock must run at least four times faster than the control clock. A new attenuation value waits in a staging register and only reaches the volume outputs on the next frame-clock edge, either rising or falling. This keeps volume steps aligned to audio frames. The format, de-emphasis and mute outputs are each the OR of a board-level pin and the matching register bit.

Top module: `serctl_port`

## Requirements
- R1: On each rising edge of `ctl_clk`, the current `ctl_data` bit shifts into the word. Bits arrive most significant first. When more than 16 bits arrive before a latch, only the last 16 are used.
- R2: The configuration and volume registers change only on a rising edge of `ctl_latch`. Shifting bits without a latch edge leaves every output unchanged.
- R3: The committed word is decoded as follows: bits [15:14] give the format code, bit 13 soft power-down, bit 12 de-emphasis, bit 11 mute (1 = muted), bit 10 channel select, and bits [9:0] volume.
- R4: Bit 10 set to 1 writes the right volume and set to 0 writes the left volume; the other channel's volume is not changed. The format, power-down, de-emphasis and mute fields update on every write, whatever bit 10 holds.
- R5: A written volume reaches `vol_left`/`vol_right` only after the next edge, rising or falling, of `frame_clk`. Until that edge, the previous volume stays on the output.
- R6: After `rst` is high, or while the synchronised `pd_n` is low, the outputs take their defaults: both volumes 0x3FF, mute 0, format 00, soft power-down 0 and de-emphasis 0.
- R7: `fmt_mode`, `deemph` and `mute` are the bitwise OR of the register field and the pins `pin_mode`, `pin_deemph` and `pin_mute`. `soft_pd` comes from the register alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous power-down, active low; restores defaults |
| ctl_clk | input | 1 | Serial control clock |
| ctl_data | input | 1 | Serial control data, MSB first |
| ctl_latch | input | 1 | Commit strobe, rising-edge active |
| frame_clk | input | 1 | Audio frame clock; either edge releases staged volumes |
| pin_mode | input | 2 | Pin-level format code, ORed with register |
| pin_deemph | input | 1 | Pin-level de-emphasis, ORed with register |
| pin_mute | input | 1 | Pin-level mute, ORed with register |
| fmt_mode | output | 2 | Effective input format code |
| soft_pd | output | 1 | Soft power-down request |
| deemph | output | 1 | Effective de-emphasis enable |
| mute | output | 1 | Effective mute |
| vol_left | output | 10 | Left attenuation request |
| vol_right | output | 10 | Right attenuation request |

## Verification
Each asynchronous event passes through two synchroniser flops, one edge-detect compare and one register stage before the registered output. These events are a latch edge, a frame-clock edge and a change on `pd_n`. Their results therefore appear on the ports on the third system-clock edge after the edge that first samples the input. A change on a mode pin passes through only the output register, so it appears one edge later. The bench drives every input on the falling clock edge and then waits six cycles before it samples any output. This wait is longer than the longest of these paths. To check volume staging, the bench samples the volume outputs after the latch but before any frame edge, and samples them again after one frame-clock toggle.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int WORD_W  = 16;
  localparam int VOL_W   = 10;
  localparam int MODE_W  = 2;
  localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

  // Field order follows the wire order of the command word (MSB first)
  typedef struct packed {
    logic [MODE_W-1:0] mode;    // [15:14]
    logic              spd;     // [13]
    logic              deemph;  // [12]
    logic              mute;    // [11]
    logic              chsel;   // [10] 1 = right
    logic [VOL_W-1:0]  vol;     // [9:0]
  } cmd_word_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              slat_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic              sclk_q, slat_q;
  logic [WORD_W-1:0] shreg;
  logic              clk_rise;

  assign clk_rise = sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      slat_q <= 1'b0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      slat_q <= slat_s;
      if (clr)           shreg <= '0;
      else if (clk_rise) shreg <= {shreg[WORD_W-2:0], sdat_s};
    end
  end

  assign word_o   = shreg;
  assign commit_o = slat_s & ~slat_q & ~clr;

  // R1: newest bit enters at the bottom of the word
  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && !clr) |=> shreg[0] == $past(sdat_s));

  // R1: older bits move one place toward the MSB
  a_r1_msb_first: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && !clr) |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  input  logic              frame_s,
  output logic [MODE_W-1:0] mode_q,
  output logic              spd_q,
  output logic              deemph_q,
  output logic              mute_q,
  output logic [VOL_W-1:0]  live_l,
  output logic [VOL_W-1:0]  live_r
);
  cmd_word_t        cmd;
  logic             frame_q, frame_edge;
  logic [VOL_W-1:0] staged_l, staged_r;

  assign cmd        = cmd_word_t'(word);
  assign frame_edge = frame_s ^ frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b0;
    else     frame_q <= frame_s;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mode_q   <= '0;
      spd_q    <= 1'b0;
      deemph_q <= 1'b0;
      mute_q   <= 1'b0;
      staged_l <= VOL_DEFAULT;
      staged_r <= VOL_DEFAULT;
      live_l   <= VOL_DEFAULT;
      live_r   <= VOL_DEFAULT;
    end else begin
      if (commit) begin
        mode_q   <= cmd.mode;
        spd_q    <= cmd.spd;
        deemph_q <= cmd.deemph;
        mute_q   <= cmd.mute;
        if (cmd.chsel) staged_r <= cmd.vol;
        else           staged_l <= cmd.vol;
      end
      if (frame_edge) begin
        live_l <= staged_l;
        live_r <= staged_r;
      end
    end
  end

  // R5: live volume moves only on a frame edge
  a_r5_hold_left: assert property (@(posedge clk) disable iff (rst)
    (!frame_edge && !clr) |=> $stable(live_l));
  a_r5_hold_right: assert property (@(posedge clk) disable iff (rst)
    (!frame_edge && !clr) |=> $stable(live_r));

  // R4: a write to one channel leaves the other channel's staging alone
  a_r4_route_left: assert property (@(posedge clk) disable iff (rst)
    (commit && cmd.chsel && !clr) |=> $stable(staged_l));
  a_r4_route_right: assert property (@(posedge clk) disable iff (rst)
    (commit && !cmd.chsel && !clr) |=> $stable(staged_r));

  // R3: mute field taken from bit 11 of the committed word
  a_r3_mute_field: assert property (@(posedge clk) disable iff (rst)
    (commit && !clr) |=> mute_q == $past(word[11]));

  // R6: power-down restores defaults
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (live_l == VOL_DEFAULT && live_r == VOL_DEFAULT && !mute_q && mode_q == '0));
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic              ctl_clk,
  input  logic              ctl_data,
  input  logic              ctl_latch,
  input  logic              frame_clk,
  input  logic [MODE_W-1:0] pin_mode,
  input  logic              pin_deemph,
  input  logic              pin_mute,
  output logic [MODE_W-1:0] fmt_mode,
  output logic              soft_pd,
  output logic              deemph,
  output logic              mute,
  output logic [VOL_W-1:0]  vol_left,
  output logic [VOL_W-1:0]  vol_right
);
  localparam int NSIG = 4;

  logic [NSIG-1:0]   raw_s;
  logic              pd_s, clr;
  logic [WORD_W-1:0] word;
  logic              commit;
  logic [MODE_W-1:0] mode_q;
  logic              spd_q, deemph_q, mute_q;
  logic [VOL_W-1:0]  live_l, live_r;

  serctl_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_ser (
    .clk(clk), .rst(rst),
    .d({frame_clk, ctl_latch, ctl_data, ctl_clk}),
    .q(raw_s)
  );

  serctl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_pd (
    .clk(clk), .rst(rst), .d(pd_n), .q(pd_s)
  );

  assign clr = ~pd_s;

  serctl_shift u_shift (
    .clk(clk), .rst(rst), .clr(clr),
    .sclk_s(raw_s[0]), .sdat_s(raw_s[1]), .slat_s(raw_s[2]),
    .word_o(word), .commit_o(commit)
  );

  serctl_regs u_regs (
    .clk(clk), .rst(rst), .clr(clr), .commit(commit), .word(word),
    .frame_s(raw_s[3]),
    .mode_q(mode_q), .spd_q(spd_q), .deemph_q(deemph_q), .mute_q(mute_q),
    .live_l(live_l), .live_r(live_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_mode  <= '0;
      soft_pd   <= 1'b0;
      deemph    <= 1'b0;
      mute      <= 1'b0;
      vol_left  <= VOL_DEFAULT;
      vol_right <= VOL_DEFAULT;
    end else begin
      fmt_mode  <= mode_q | pin_mode;
      soft_pd   <= spd_q;
      deemph    <= deemph_q | pin_deemph;
      mute      <= mute_q | pin_mute;
      vol_left  <= live_l;
      vol_right <= live_r;
    end
  end

  // R7: a pin held high always forces the matching output
  a_r7_pin_mute: assert property (@(posedge clk) disable iff (rst)
    pin_mute |=> mute);
  a_r7_pin_deemph: assert property (@(posedge clk) disable iff (rst)
    pin_deemph |=> deemph);
endmodule

// File: tb/tb_serctl_port.sv
`timescale 1ns/1ps
module tb_serctl_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_n = 1'b1;
  logic       ctl_clk = 1'b0, ctl_data = 1'b0, ctl_latch = 1'b0, frame_clk = 1'b0;
  logic [1:0] pin_mode = 2'b00;
  logic       pin_deemph = 1'b0, pin_mute = 1'b0;
  logic [1:0] fmt_mode;
  logic       soft_pd, deemph, mute;
  logic [9:0] vol_left, vol_right;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  serctl_port dut (
    .clk(clk), .rst(rst), .pd_n(pd_n),
    .ctl_clk(ctl_clk), .ctl_data(ctl_data), .ctl_latch(ctl_latch),
    .frame_clk(frame_clk), .pin_mode(pin_mode), .pin_deemph(pin_deemph),
    .pin_mute(pin_mute), .fmt_mode(fmt_mode), .soft_pd(soft_pd),
    .deemph(deemph), .mute(mute), .vol_left(vol_left), .vol_right(vol_right)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input int m, input int p, input int d,
                           input int mu, input int vl, input int vr);
    check({tag, " fmt_mode"}, fmt_mode, m);
    check({tag, " soft_pd"}, soft_pd, p);
    check({tag, " deemph"}, deemph, d);
    check({tag, " mute"}, mute, mu);
    check({tag, " vol_left"}, vol_left, vl);
    check({tag, " vol_right"}, vol_right, vr);
  endtask

  task automatic shift_bits(input logic [31:0] val, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ctl_data = val[i];
      step(4);
      ctl_clk = 1'b1;
      step(4);
      ctl_clk = 1'b0;
      step(2);
    end
  endtask

  task automatic pulse_latch();
    ctl_latch = 1'b1;
    step(6);
    ctl_latch = 1'b0;
    step(6);
  endtask

  task automatic send_word(input logic [15:0] w);
    shift_bits({16'h0, w}, 16);
    pulse_latch();
  endtask

  task automatic frame_toggle();
    frame_clk = ~frame_clk;
    step(6);
  endtask

  task automatic t_reset();
    check_all("R6 reset", 0, 0, 0, 0, 10'h3FF, 10'h3FF);
  endtask

  task automatic t_left_write();
    send_word(16'h0155);
    check("R5 left held before frame", vol_left, 10'h3FF);
    frame_toggle();
    check("R5 left after frame", vol_left, 10'h155);
    check("R4 right untouched", vol_right, 10'h3FF);
  endtask

  task automatic t_right_write();
    send_word(16'h8CAA);  // mode 10, mute, right, vol 0x0AA
    check("R3 mode field", fmt_mode, 2);
    check("R3 mute field", mute, 1);
    check("R5 right held before frame", vol_right, 10'h3FF);
    frame_toggle();  // falling frame edge
    check("R5 right after falling frame", vol_right, 10'h0AA);
    check("R4 left untouched", vol_left, 10'h155);
  endtask

  task automatic t_no_latch();
    shift_bits(32'h0000_0000, 16);
    step(6);
    frame_toggle();
    check_all("R2 no latch", 2, 0, 0, 1, 10'h155, 10'h0AA);
  endtask

  task automatic t_overlong();
    shift_bits(32'h000F_3123, 20);  // last 16 bits = 0x3123
    pulse_latch();
    frame_toggle();
    check_all("R1 last 16 bits", 0, 1, 1, 0, 10'h123, 10'h0AA);
  endtask

  task automatic t_pins();
    pin_mute = 1'b1;
    pin_mode = 2'b01;
    step(6);
    check("R7 pin mute", mute, 1);
    check("R7 pin mode", fmt_mode, 1);
    send_word(16'h4000);  // mode 01, left vol 0
    pin_mode = 2'b10;
    step(6);
    check("R7 mode OR", fmt_mode, 3);
    check("R4 pd cleared on left write", soft_pd, 0);
    check("R7 deemph reg cleared", deemph, 0);
    pin_deemph = 1'b1;
    step(6);
    check("R7 pin deemph", deemph, 1);
    pin_mute = 1'b0; pin_mode = 2'b00; pin_deemph = 1'b0;
    step(6);
    frame_toggle();
    check_all("R7 pins released", 1, 0, 0, 0, 10'h000, 10'h0AA);
  endtask

  task automatic t_powerdown();
    pd_n = 1'b0;
    step(6);
    check_all("R6 power-down", 0, 0, 0, 0, 10'h3FF, 10'h3FF);
    pd_n = 1'b1;
    step(6);
    send_word(16'h0800);
    check("R6 writes resume", mute, 1);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(4);
    t_reset();
    t_left_write();
    t_right_write();
    t_no_latch();
    t_overlong();
    t_pins();
    t_powerdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule